// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a network controller whose frames are described by a chain of 16-byte descriptors in system memory. Software builds the chain, marks each descriptor as engine-owned, turns transmit on and then pulses a start demand. The walker fetches each descriptor through a single-word memory master port. It checks ownership and hands the buffer address and frame length to a downstream frame sender, which moves the payload bytes. It then returns the descriptor to software with a completion status and follows the next-pointer.

The walk continues back to back until a descriptor that software still owns is found, a descriptor read fails, or transmit is turned off. Short frames can be padded per descriptor up to a minimum length (parameter `MIN_LEN`, 60 bytes by default). Three single-cycle event pulses (frame complete, descriptor unavailable, bus error) feed the interrupt logic. A sticky halted flag records each time transmit is switched off.

Top module: `txring_engine`

## Requirements
- R1: Descriptor at byte address D holds four words read from D, D+4, D+8 and D+12: flags, buffer start address, status-and-length, next-descriptor address; each handed-off frame carries the buffer address taken from word D+4.
- R2: A 0-to-1 change of `tx_en` loads `cur_desc` from `list_base` (bits 1:0 forced to zero) without any memory access; fetching begins only on a `start_req` pulse while `tx_en` is high, and `start_req` while `tx_en` is low has no effect.
- R3: If flags bit 31 (engine owns) is 0, the walker stops, pulses `ev_unavail`, leaves that descriptor in memory untouched and keeps `cur_desc` pointing at it.
- R4: For an owned descriptor the flags word is written back with bit 31 cleared and all other bits unchanged; status bits 31:16 are written back as zero except the bits named in R6 and R7, and bits 15:0 keep the length.
- R5: The frame length is status bits 15:0; when flags bit 0 (pad enable) is 1 and that length is below `MIN_LEN`, the length handed to the sender is `MIN_LEN`, otherwise the length is unchanged.
- R6: After a successful send, status bit 19 (complete) is set; `ev_done` pulses only when flags bit 2 (interrupt enable) is 1.
- R7: Status bit 18 (interrupt flag) is set on a successful send when `irq_live` is high during the status writeback.
- R8: A memory error on any descriptor word read stops the walker, pulses `ev_buserr` and leaves `cur_desc` on the failing descriptor.
- R9: A sender error (`frm_err` with `frm_ready`) pulses `ev_buserr`, leaves status bits 19 and 18 clear, still writes both words back and moves on to the next descriptor.
- R10: After the writeback, `cur_desc` takes the next-descriptor word with bits 1:0 forced to zero and the next fetch starts without a new demand.
- R11: With `tx_en` low the walker is idle one cycle later; each 1-to-0 change of `tx_en` sets `halted`, which `stat_clr` clears, a simultaneous set winning.
- R12: Once raised without `mem_ack`, `mem_req` stays high with the same address, direction and data until acknowledged, provided `tx_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable level |
| start_req | input | 1 | Start-demand pulse |
| list_base | input | AW | Address of the first descriptor |
| irq_live | input | 1 | Transmit interrupt pending and enabled |
| stat_clr | input | 1 | Clears the halted flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| frm_valid | output | 1 | Frame offered to the sender |
| frm_addr | output | AW | Frame buffer address |
| frm_len | output | 16 | Frame length after padding |
| frm_ready | input | 1 | Sender finished with the frame |
| frm_err | input | 1 | Sender hit a buffer read error |
| cur_desc | output | AW | Current descriptor address |
| cur_buf | output | AW | Current buffer address |
| ev_done | output | 1 | Frame complete pulse |
| ev_unavail | output | 1 | Descriptor unavailable pulse |
| ev_buserr | output | 1 | Bus error pulse |
| busy | output | 1 | Walker active |
| halted | output | 1 | Sticky transmit-halted flag |

## Verification
One sweep runs an eight-entry chain twice, once without padding and with a zero-wait memory, once with padding and a memory that stalls every other cycle. The lengths straddle `MIN_LEN` (0, 1, 59, 60, 61, 100, 1500, 65535), so the pass pair separates padded from raw lengths and exposes any off-by-one at the threshold. Alternating interrupt-enable flags and dirty upper status bits tell event gating and status clearing apart. Further chains separate a buffer error, which keeps walking, from a descriptor read error, which stops. Further runs cover the interrupt-flag input, demands while disabled, a base reload without fetching, and a mid-walk disable.

// File: rtl/txring_pkg.sv
`timescale 1ns/1ps
package txring_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RFLG,
        S_RBUF,
        S_RLEN,
        S_RNXT,
        S_SEND,
        S_WFLG,
        S_WSTS
    } tx_state_e;

    // descriptor field positions (software-visible layout)
    localparam int OWN_BIT   = 31;
    localparam int INTEN_BIT = 2;
    localparam int PAD_BIT   = 0;
    localparam int CMP_BIT   = 19;
    localparam int IRQF_BIT  = 18;
    localparam int LEN_W     = 16;

    // word offsets inside a descriptor
    localparam int OFS_FLG = 0;
    localparam int OFS_BUF = 4;
    localparam int OFS_LEN = 8;
    localparam int OFS_NXT = 12;

endpackage

// File: rtl/txring_lenfix.sv
`timescale 1ns/1ps
module txring_lenfix #(
    parameter int LW      = 16,
    parameter int MIN_LEN = 60
) (
    input  logic          pad_en,
    input  logic [LW-1:0] len_in,
    output logic [LW-1:0] len_out
);
    localparam logic [LW-1:0] MIN_V = LW'(MIN_LEN);

    always_comb begin
        if (pad_en && (len_in < MIN_V)) begin
            len_out = MIN_V;
        end else begin
            len_out = len_in;
        end
    end
endmodule

// File: rtl/txring_edge.sv
`timescale 1ns/1ps
module txring_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic stat_clr,
    output logic en_rise,
    output logic halted
);
    typedef struct packed {
        logic en;
        logic halt;
    } edge_t;

    edge_t e_d, e_q;
    logic  en_fall;

    always_comb begin
        en_rise = tx_en & ~e_q.en;
        en_fall = ~tx_en & e_q.en;
        e_d     = e_q;
        e_d.en  = tx_en;
        if (en_fall) begin
            e_d.halt = 1'b1;
        end else if (stat_clr) begin
            e_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign halted = e_q.halt;

    // R11
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> halted);

    // R11
    halt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !en_fall) |=> !halted);
endmodule

// File: rtl/txring_engine.sv
`timescale 1ns/1ps
module txring_engine
    import txring_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MIN_LEN = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             start_req,
    input  logic [AW-1:0]    list_base,
    input  logic             irq_live,
    input  logic             stat_clr,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             frm_valid,
    output logic [AW-1:0]    frm_addr,
    output logic [LEN_W-1:0] frm_len,
    input  logic             frm_ready,
    input  logic             frm_err,
    output logic [AW-1:0]    cur_desc,
    output logic [AW-1:0]    cur_buf,
    output logic             ev_done,
    output logic             ev_unavail,
    output logic             ev_buserr,
    output logic             busy,
    output logic             halted
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);

    typedef struct packed {
        tx_state_e        st;
        logic [AW-1:0]    desc;
        logic [AW-1:0]    bufa;
        logic [31:0]      flg;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    nxt;
        logic             buf_err;
        logic             ev_done;
        logic             ev_unav;
        logic             ev_berr;
    } eng_t;

    eng_t r_d, r_q;

    logic          en_rise;
    logic [AW-1:0] ofs;
    logic [31:0]   sts_word;
    logic          send_ok;

    txring_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .stat_clr(stat_clr),
        .en_rise (en_rise),
        .halted  (halted)
    );

    txring_lenfix #(
        .LW     (LEN_W),
        .MIN_LEN(MIN_LEN)
    ) u_lenfix (
        .pad_en (r_q.flg[PAD_BIT]),
        .len_in (r_q.len),
        .len_out(frm_len)
    );

    // memory port decode
    always_comb begin
        unique case (r_q.st)
            S_RFLG, S_WFLG: ofs = AW'(OFS_FLG);
            S_RBUF:         ofs = AW'(OFS_BUF);
            S_RLEN, S_WSTS: ofs = AW'(OFS_LEN);
            S_RNXT:         ofs = AW'(OFS_NXT);
            default:        ofs = '0;
        endcase
    end

    always_comb begin
        send_ok            = ~r_q.buf_err;
        sts_word           = 32'(r_q.len);
        sts_word[CMP_BIT]  = send_ok;
        sts_word[IRQF_BIT] = send_ok & irq_live;
    end

    assign mem_req  = (r_q.st == S_RFLG) || (r_q.st == S_RBUF) ||
                      (r_q.st == S_RLEN) || (r_q.st == S_RNXT) ||
                      (r_q.st == S_WFLG) || (r_q.st == S_WSTS);
    assign mem_we   = (r_q.st == S_WFLG) || (r_q.st == S_WSTS);
    assign mem_addr = r_q.desc + ofs;

    always_comb begin
        if (r_q.st == S_WFLG) begin
            mem_wdata = r_q.flg & ~(32'd1 << OWN_BIT);
        end else if (r_q.st == S_WSTS) begin
            mem_wdata = sts_word;
        end else begin
            mem_wdata = '0;
        end
    end

    // next-state logic
    always_comb begin
        r_d         = r_q;
        r_d.ev_done = 1'b0;
        r_d.ev_unav = 1'b0;
        r_d.ev_berr = 1'b0;

        if (en_rise) begin
            r_d.desc = list_base & ALIGN_MASK;
        end

        if (!tx_en) begin
            r_d.st = S_IDLE;
        end else begin
            unique case (r_q.st)
                S_IDLE: begin
                    if (start_req) r_d.st = S_RFLG;
                end
                S_RFLG: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            r_d.st      = S_IDLE;
                            r_d.ev_berr = 1'b1;
                        end else if (!mem_rdata[OWN_BIT]) begin
                            r_d.st      = S_IDLE;
                            r_d.ev_unav = 1'b1;
                        end else begin
                            r_d.flg = mem_rdata;
                            r_d.st  = S_RBUF;
                        end
                    end
                end
                S_RBUF: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            r_d.st      = S_IDLE;
                            r_d.ev_berr = 1'b1;
                        end else begin
                            r_d.bufa = mem_rdata[AW-1:0];
                            r_d.st   = S_RLEN;
                        end
                    end
                end
                S_RLEN: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            r_d.st      = S_IDLE;
                            r_d.ev_berr = 1'b1;
                        end else begin
                            r_d.len = mem_rdata[LEN_W-1:0];
                            r_d.st  = S_RNXT;
                        end
                    end
                end
                S_RNXT: begin
                    if (mem_ack) begin
                        if (mem_err) begin
                            r_d.st      = S_IDLE;
                            r_d.ev_berr = 1'b1;
                        end else begin
                            r_d.nxt = mem_rdata[AW-1:0] & ALIGN_MASK;
                            r_d.st  = S_SEND;
                        end
                    end
                end
                S_SEND: begin
                    if (frm_ready) begin
                        r_d.buf_err = frm_err;
                        r_d.ev_berr = frm_err;
                        r_d.st      = S_WFLG;
                    end
                end
                S_WFLG: begin
                    if (mem_ack) begin
                        r_d.ev_berr = mem_err;
                        r_d.st      = S_WSTS;
                    end
                end
                S_WSTS: begin
                    if (mem_ack) begin
                        r_d.ev_berr = mem_err;
                        r_d.ev_done = ~r_q.buf_err & r_q.flg[INTEN_BIT];
                        r_d.desc    = r_q.nxt;
                        r_d.st      = S_RFLG;
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign frm_valid  = (r_q.st == S_SEND);
    assign frm_addr   = r_q.bufa;
    assign cur_desc   = r_q.desc;
    assign cur_buf    = r_q.bufa;
    assign ev_done    = r_q.ev_done;
    assign ev_unavail = r_q.ev_unav;
    assign ev_buserr  = r_q.ev_berr;
    assign busy       = (r_q.st != S_IDLE);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && tx_en) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !busy);

    // R5
    pad_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && r_q.flg[PAD_BIT]) |-> (frm_len >= LEN_W'(MIN_LEN)));

    // R5
    len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> (frm_len >= r_q.len));

    // R3
    unav_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unavail |-> (!ev_done && !ev_buserr && !busy));

    // R8
    desc_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && mem_err && tx_en) |=> (!busy && ev_buserr));

    // R6
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> $past(mem_we && mem_ack));
endmodule

// File: tb/tb_txring_engine.sv
`timescale 1ns/1ps
module tb_txring_engine;
    localparam int AW   = 32;
    localparam int MINL = 60;
    localparam logic [31:0] OWN   = 32'h8000_0000;
    localparam logic [31:0] INTEN = 32'h0000_0004;
    localparam logic [31:0] PAD   = 32'h0000_0001;
    localparam logic [31:0] CMP   = 32'h0008_0000;
    localparam logic [31:0] IRQF  = 32'h0004_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0, start_req = 1'b0, irq_live = 1'b0, stat_clr = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          mem_req, mem_we, mem_ack, mem_err;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          frm_valid, frm_ready, frm_err;
    logic [AW-1:0] frm_addr, cur_desc, cur_buf;
    logic [15:0]   frm_len;
    logic          ev_done, ev_unavail, ev_buserr, busy, halted;

    txring_engine #(.AW(AW), .MIN_LEN(MINL)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .start_req(start_req),
        .list_base(list_base), .irq_live(irq_live), .stat_clr(stat_clr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_len(frm_len),
        .frm_ready(frm_ready), .frm_err(frm_err),
        .cur_desc(cur_desc), .cur_buf(cur_buf), .ev_done(ev_done),
        .ev_unavail(ev_unavail), .ev_buserr(ev_buserr), .busy(busy), .halted(halted)
    );

    // memory model: 256 words at 0x000..0x3FF, anything above errors
    logic [31:0] mem [0:255];
    logic        stall_on = 1'b0;
    logic        phase = 1'b0;
    logic        tb_we = 1'b0;
    logic [7:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;

    assign mem_ack   = mem_req & ~(stall_on & phase);
    assign mem_err   = (mem_addr >= 32'h400);
    assign mem_rdata = (mem_addr < 32'h400) ? mem[mem_addr[9:2]] : 32'hDEAD_BEEF;
    assign frm_ready = frm_valid;
    assign frm_err   = frm_addr[31];

    logic [31:0] log_addr [0:15];
    logic [15:0] log_len  [0:15];
    int nfrm = 0, ndone = 0, nunav = 0, nberr = 0, nreq = 0;

    always @(negedge clk) begin
        if (tb_we) mem[tb_wa] <= tb_wd;
        else if (mem_req && mem_we && mem_addr < 32'h400) mem[mem_addr[9:2]] <= mem_wdata;
        phase <= ~phase;
        if (frm_valid) begin
            log_addr[nfrm[3:0]] <= frm_addr;
            log_len[nfrm[3:0]]  <= frm_len;
            nfrm <= nfrm + 1;
        end
        ndone <= ndone + int'(ev_done);
        nunav <= nunav + int'(ev_unavail);
        nberr <= nberr + int'(ev_buserr);
        nreq  <= nreq + int'(mem_req);
    end

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;
    int f0, d0, u0, b0, q0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] addr, input logic [31:0] val);
        tb_we = 1'b1; tb_wa = addr[9:2]; tb_wd = val;
        @(negedge clk);
        #1 tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] f, input logic [31:0] b,
                            input logic [31:0] s, input logic [31:0] n);
        put(a, f); put(a + 4, b); put(a + 8, s); put(a + 12, n);
    endtask

    task automatic snap();
        f0 = nfrm; d0 = ndone; u0 = nunav; b0 = nberr; q0 = nreq;
    endtask

    task automatic enable(input logic [31:0] base);
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk); list_base = base; tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic kick_and_wait();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        for (int k = 0; k < 4000 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] len_of(input int i);
        case (i)
            0: return 16'd0;      1: return 16'd1;
            2: return 16'd59;     3: return 16'd60;
            4: return 16'd61;     5: return 16'd100;
            6: return 16'd1500;   default: return 16'hFFFF;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1111_1111;
        repeat (3) @(negedge clk);
        chk("reset busy", 32'(busy), 0);
        chk("reset mem_req", 32'(mem_req), 0);
        chk("reset cur_desc", cur_desc, 0);
        chk("reset halted", 32'(halted), 0);
        chk("reset events", 32'({ev_done, ev_unavail, ev_buserr}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: pass 0 raw lengths no stall, pass 1 padded lengths with stalls
        for (int p = 0; p < 2; p++) begin
            stall_on = (p == 1);
            for (int i = 0; i < 8; i++) begin
                put_desc(32'h100 + 16 * i,
                         OWN | 32'h0000_0F00 | (p == 1 ? PAD : 32'h0) | ((i % 2) == 1 ? INTEN : 32'h0),
                         32'h1000 + 32'h40 * i,
                         32'hABC0_0000 | 32'(len_of(i)),
                         (i == 7) ? 32'h183 : 32'h110 + 16 * i);
            end
            put_desc(32'h180, 32'h0000_0F05, 32'h7000, 32'h0000_0020, 32'h100);
            enable(32'h100);
            chk("R2 base loaded on enable", cur_desc, 32'h100);
            chk("R2 no fetch before demand", 32'(busy), 0);
            snap();
            kick_and_wait();
            chk("R10 frames walked", 32'(nfrm - f0), 8);
            for (int i = 0; i < 8; i++) begin
                logic [15:0] el;
                el = (p == 1 && len_of(i) < 16'(MINL)) ? 16'(MINL) : len_of(i);
                chk("R1 frame buffer address", log_addr[(f0 + i) % 16], 32'h1000 + 32'h40 * i);
                chk("R5 frame length", 32'(log_len[(f0 + i) % 16]), 32'(el));
                chk("R4 flags writeback", mem[(32'h100 + 16 * i) >> 2],
                    32'h0000_0F00 | (p == 1 ? PAD : 32'h0) | ((i % 2) == 1 ? INTEN : 32'h0));
                chk("R4 R6 status writeback", mem[(32'h108 + 16 * i) >> 2], CMP | 32'(len_of(i)));
            end
            chk("R6 done events gated by flag", 32'(ndone - d0), 4);
            chk("R3 unavailable event", 32'(nunav - u0), 1);
            chk("R9 no bus error", 32'(nberr - b0), 0);
            chk("R10 R3 stop on cpu-owned desc", cur_desc, 32'h180);
            chk("R3 cpu-owned flags untouched", mem[32'h180 >> 2], 32'h0000_0F05);
            chk("R3 cpu-owned status untouched", mem[32'h188 >> 2], 32'h0000_0020);
            @(negedge clk); tx_en = 1'b0;
            @(negedge clk);
            chk("R11 halted set on disable", 32'(halted), 1);
            stat_clr = 1'b1;
            @(negedge clk); stat_clr = 1'b0;
            chk("R11 halted cleared", 32'(halted), 0);
        end
        stall_on = 1'b0;

        // interrupt flag in status
        put_desc(32'h100, OWN, 32'h2000, 32'h0000_000A, 32'h110);
        put_desc(32'h110, 32'h0, 32'h2000, 32'h0, 32'h100);
        irq_live = 1'b1;
        enable(32'h100);
        snap();
        kick_and_wait();
        irq_live = 1'b0;
        chk("R7 interrupt flag in status", mem[32'h108 >> 2], CMP | IRQF | 32'd10);
        chk("R6 no done without enable flag", 32'(ndone - d0), 0);
        chk("R5 unpadded short frame", 32'(log_len[f0 % 16]), 10);

        // sender error: walk continues
        put_desc(32'h100, OWN | INTEN, 32'h8000_0040, 32'h0000_0040, 32'h110);
        put_desc(32'h110, OWN | INTEN, 32'h3000, 32'h0000_0050, 32'h120);
        put_desc(32'h120, 32'h0, 32'h0, 32'h0, 32'h0);
        enable(32'h100);
        snap();
        kick_and_wait();
        chk("R9 bus error event", 32'(nberr - b0), 1);
        chk("R9 status without complete", mem[32'h108 >> 2], 32'h0000_0040);
        chk("R9 owner returned", mem[32'h100 >> 2], INTEN);
        chk("R9 walk continued", 32'(nfrm - f0), 2);
        chk("R9 done only for good frame", 32'(ndone - d0), 1);
        chk("R9 stops at cpu-owned", cur_desc, 32'h120);

        // descriptor read error
        put_desc(32'h100, OWN, 32'h3000, 32'h0000_0050, 32'h500);
        enable(32'h100);
        snap();
        kick_and_wait();
        chk("R8 bus error on descriptor read", 32'(nberr - b0), 1);
        chk("R8 no unavailable event", 32'(nunav - u0), 0);
        chk("R8 cur_desc on failing desc", cur_desc, 32'h500);
        chk("R8 walker stopped", 32'(busy), 0);

        // demand while disabled, reload without fetch
        @(negedge clk); tx_en = 1'b0;
        snap();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        @(negedge clk);
        chk("R2 demand ignored while disabled", 32'(nreq - q0), 0);
        list_base = 32'h143; tx_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 base reload aligned", cur_desc, 32'h140);
        chk("R2 no fetch after reload", 32'(nreq - q0), 0);

        // abort mid walk
        stall_on = 1'b1;
        for (int i = 0; i < 8; i++)
            put_desc(32'h100 + 16 * i, OWN, 32'h1000, 32'h0000_0100, 32'h100 + 16 * ((i + 1) % 8));
        enable(32'h100);
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        repeat (9) @(negedge clk);
        chk("R12 busy mid walk", 32'(busy), 1);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R11 idle after disable", 32'(busy), 0);
        chk("R11 request dropped", 32'(mem_req), 0);
        chk("R11 halted after abort", 32'(halted), 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule